// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block supervises the automatic offset trim of a pickup head amplifier. A run starts on any of four triggers: leaving reset, recovery after a supply brownout, leaving sleep, or the software correction bit. While a run is in progress the block forces the datapath into the RAM-read mode and forces both servo gain paths to their highest gain. When the run ends, it sends a one-cycle preset pulse so the serial register file returns every flag to its default.

The block also does three other jobs. It decodes the two mode pins into an operating mode. It turns each effective 4-bit gain code into a signed dB value. It drives a correction-request status line, which rises on a temperature drift event and stays high until a run starts. A sticky "corrected" indicator shows whether the last run's trim is still applied. Holding both mode pins high stops the trim from taking effect, and once that happens the indicator stays low until another run completes. Run length is set in clock cycles by a parameter.

Top module: `ofs_cal_seq`

## Requirements
- R1: `op_mode` is the pin pair {wr_pin, md_pin} when no run is active: 00 RAM read, 01 ROM read, 10 RAM write with correction allowed, 11 RAM write with correction inhibited.
- R2: While reset is asserted, and from its release, the block is in a correction run: `calibrating` and `cal_req` are 1.
- R3: During a run, `op_mode` is 00, both effective codes are 0000 and both dB outputs are +14, whatever the pins and register codes.
- R4: A run lasts CAL_CYCLES clock cycles. The cycle after its last one has `preset_all`=1, `calibrating`=0 and both codes 0111; the block is idle in the cycle after that.
- R5: In the idle state, `corr_bit`=1 starts a run at the next clock edge.
- R6: `sleep_bit`=1 enters sleep at the next edge, and no run is active in that cycle even if `corr_bit`=1. The first sleep cycle has `preset_gain`=1, and both codes read 0111 for the whole sleep.
- R7: Clearing `sleep_bit` while asleep starts a run at the next edge.
- R8: `supply_low`=1 ends any run at the next edge and clears `cal_req`. No run starts, even with `corr_bit`=1, until `supply_high`=1 with `supply_low`=0; the following edge then starts a run.
- R9: `cal_req` is 1 during a run. A `temp_evt` pulse outside a run sets `cal_req` from the next edge until a run starts. `cal_req` falls when a run stops.
- R10: `corrected` rises when a run finishes with the pins not at 11 in its last cycle. It is 0 one edge after any cycle with the pins at 11, and it stays 0 after release until another run completes.
- R11: Outside a run, sleep and the preset cycle, each effective code equals its register input. Each dB output is 14 - 2*code as a 6-bit two's-complement value, so 0000 gives +14 and 1111 gives -16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| wr_pin | input | 1 | Write-select mode pin |
| md_pin | input | 1 | Disc-type mode pin |
| sleep_bit | input | 1 | Sleep control flag from the register file |
| corr_bit | input | 1 | Correction command flag from the register file |
| supply_low | input | 1 | Supply below the low comparator threshold |
| supply_high | input | 1 | Supply above the high comparator threshold |
| temp_evt | input | 1 | Temperature drift detected |
| trk_code_in | input | CODE_W | Tracking gain code from the register file |
| foc_code_in | input | CODE_W | Focus gain code from the register file |
| op_mode | output | 2 | Decoded operating mode |
| trk_code | output | CODE_W | Effective tracking gain code |
| foc_code | output | CODE_W | Effective focus gain code |
| trk_db | output | DB_W | Tracking gain in dB, signed |
| foc_db | output | DB_W | Focus gain in dB, signed |
| calibrating | output | 1 | Correction run in progress |
| cal_req | output | 1 | Correction status/request line |
| corrected | output | 1 | Trim result currently applied |
| preset_all | output | 1 | Pulse: register file returns all flags to default |
| preset_gain | output | 1 | Pulse: register file returns gain codes to default |

## Verification
A wrong state register shows up at the ports within one clock edge. A run that starts late or never starts leaves `calibrating` low while the mode and gain outputs still follow the pins. A timer off by one moves the `preset_all` pulse a cycle early or late against a count of CAL_CYCLES. A lost priority lets `calibrating` rise while sleep or brownout is in force. The sticky corrected flag is the slowest to expose a fault: an early release after an inhibit only becomes visible over the idle cycles that follow, so the bench holds the pins released for several cycles before and after runs.

// File: rtl/ocs_pkg.sv
package ocs_pkg;

   typedef enum logic [1:0] {
      OPM_RAM_RD    = 2'b00,
      OPM_ROM_RD    = 2'b01,
      OPM_RAM_WR    = 2'b10,
      OPM_RAM_WR_NC = 2'b11
   } opmode_e;

   typedef enum logic [2:0] {
      ST_CAL   = 3'd0,
      ST_DONE  = 3'd1,
      ST_IDLE  = 3'd2,
      ST_SLEEP = 3'd3,
      ST_BROWN = 3'd4
   } seq_state_e;

   localparam int NPATH = 2;

endpackage

// File: rtl/ocs_mode_dec.sv
module ocs_mode_dec
   import ocs_pkg::*;
(
   input  logic    wr_pin,
   input  logic    md_pin,
   input  logic    force_rd,
   output opmode_e op_mode,
   output logic    inhibit
);
   always_comb begin
      inhibit = wr_pin & md_pin;
      if (force_rd) op_mode = OPM_RAM_RD;
      else          op_mode = opmode_e'({wr_pin, md_pin});
   end
endmodule

// File: rtl/ocs_gain_path.sv
module ocs_gain_path #(
   parameter int CODE_W  = 4,
   parameter int DB_W    = 6,
   parameter int DB_TOP  = 14,
   parameter int DB_STEP = 2
) (
   input  logic                     [CODE_W-1:0] code_in,
   input  logic                                  force_max,
   input  logic                                  force_dflt,
   output logic                     [CODE_W-1:0] code_out,
   output logic signed              [DB_W-1:0]   db_out
);
   localparam logic [CODE_W-1:0] CODE_MAXG = '0;
   localparam logic [CODE_W-1:0] CODE_DFLT = CODE_W'((1 << (CODE_W - 1)) - 1);

   always_comb begin
      if (force_max)       code_out = CODE_MAXG;
      else if (force_dflt) code_out = CODE_DFLT;
      else                 code_out = code_in;
      db_out = DB_W'(DB_TOP - DB_STEP * int'(code_out));
   end
endmodule

// File: rtl/ocs_cal_fsm.sv
module ocs_cal_fsm
   import ocs_pkg::*;
#(
   parameter int CAL_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic corr_req,
   input  logic sup_low,
   input  logic sup_high,
   input  logic temp_evt,
   input  logic inhibit,
   output logic calibrating,
   output logic done_pulse,
   output logic sleep_entry,
   output logic sleeping,
   output logic cal_req,
   output logic corrected
);
   localparam int                TMR_W    = $clog2(CAL_CYCLES + 1);
   localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(CAL_CYCLES - 1);

   seq_state_e       state, nxt;
   logic [TMR_W-1:0] tmr;
   logic             was_sleep;
   logic             temp_pend;
   logic             start;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_CAL: begin
            if (sup_low)              nxt = ST_BROWN;
            else if (sleep_req)       nxt = ST_SLEEP;
            else if (tmr == TMR_LAST) nxt = ST_DONE;
         end
         ST_DONE: begin
            if (sup_low)        nxt = ST_BROWN;
            else if (sleep_req) nxt = ST_SLEEP;
            else                nxt = ST_IDLE;
         end
         ST_IDLE: begin
            if (sup_low)        nxt = ST_BROWN;
            else if (sleep_req) nxt = ST_SLEEP;
            else if (corr_req)  nxt = ST_CAL;
         end
         ST_SLEEP: begin
            if (sup_low)         nxt = ST_BROWN;
            else if (!sleep_req) nxt = ST_CAL;
         end
         ST_BROWN: begin
            if (sup_high && !sup_low) nxt = sleep_req ? ST_SLEEP : ST_CAL;
         end
         default: nxt = ST_CAL;
      endcase
   end

   assign start = (nxt == ST_CAL) && (state != ST_CAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_CAL;
         tmr       <= '0;
         was_sleep <= 1'b0;
         temp_pend <= 1'b0;
         corrected <= 1'b0;
      end else begin
         state     <= nxt;
         tmr       <= (state == ST_CAL && nxt == ST_CAL) ? tmr + 1'b1 : '0;
         was_sleep <= (state == ST_SLEEP);
         if (start)                              temp_pend <= 1'b0;
         else if (temp_evt && state != ST_CAL)   temp_pend <= 1'b1;
         if (inhibit)                                corrected <= 1'b0;
         else if (state == ST_CAL && nxt == ST_DONE) corrected <= 1'b1;
         else if (start || nxt == ST_BROWN)          corrected <= 1'b0;
      end
   end

   assign calibrating = (state == ST_CAL);
   assign done_pulse  = (state == ST_DONE);
   assign sleeping    = (state == ST_SLEEP);
   assign sleep_entry = (state == ST_SLEEP) && !was_sleep;
   assign cal_req     = calibrating | temp_pend;
endmodule

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq
   import ocs_pkg::*;
#(
   parameter int CODE_W     = 4,
   parameter int DB_W       = 6,
   parameter int DB_TOP     = 14,
   parameter int DB_STEP    = 2,
   parameter int CAL_CYCLES = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_pin,
   input  logic                     md_pin,
   input  logic                     sleep_bit,
   input  logic                     corr_bit,
   input  logic                     supply_low,
   input  logic                     supply_high,
   input  logic                     temp_evt,
   input  logic [CODE_W-1:0]        trk_code_in,
   input  logic [CODE_W-1:0]        foc_code_in,
   output logic [1:0]               op_mode,
   output logic [CODE_W-1:0]        trk_code,
   output logic [CODE_W-1:0]        foc_code,
   output logic signed [DB_W-1:0]   trk_db,
   output logic signed [DB_W-1:0]   foc_db,
   output logic                     calibrating,
   output logic                     cal_req,
   output logic                     corrected,
   output logic                     preset_all,
   output logic                     preset_gain
);
   localparam int DB_MIN = DB_TOP - DB_STEP * ((1 << CODE_W) - 1);

   if (CAL_CYCLES < 2) begin : g_bad_len
      $error("CAL_CYCLES must be at least 2");
   end
   if (CODE_W < 2) begin : g_bad_code
      $error("CODE_W must be at least 2");
   end
   if (DB_TOP >= (1 << (DB_W - 1)) || DB_MIN < -(1 << (DB_W - 1))) begin : g_bad_db
      $error("DB_W too narrow for the gain range");
   end

   opmode_e mode_e;
   logic    inhibit;
   logic    sleeping;

   ocs_mode_dec u_mode (
      .wr_pin   (wr_pin),
      .md_pin   (md_pin),
      .force_rd (calibrating),
      .op_mode  (mode_e),
      .inhibit  (inhibit)
   );
   assign op_mode = mode_e;

   ocs_cal_fsm #(.CAL_CYCLES(CAL_CYCLES)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_bit),
      .corr_req    (corr_bit),
      .sup_low     (supply_low),
      .sup_high    (supply_high),
      .temp_evt    (temp_evt),
      .inhibit     (inhibit),
      .calibrating (calibrating),
      .done_pulse  (preset_all),
      .sleep_entry (preset_gain),
      .sleeping    (sleeping),
      .cal_req     (cal_req),
      .corrected   (corrected)
   );

   logic [CODE_W-1:0]      code_in_a  [NPATH];
   logic [CODE_W-1:0]      code_out_a [NPATH];
   logic signed [DB_W-1:0] db_a       [NPATH];

   assign code_in_a[0] = trk_code_in;
   assign code_in_a[1] = foc_code_in;

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      ocs_gain_path #(
         .CODE_W (CODE_W),
         .DB_W   (DB_W),
         .DB_TOP (DB_TOP),
         .DB_STEP(DB_STEP)
      ) u_gain (
         .code_in    (code_in_a[p]),
         .force_max  (calibrating),
         .force_dflt (sleeping | preset_all),
         .code_out   (code_out_a[p]),
         .db_out     (db_a[p])
      );
   end

   assign trk_code = code_out_a[0];
   assign foc_code = code_out_a[1];
   assign trk_db   = db_a[0];
   assign foc_db   = db_a[1];
endmodule

// File: rtl/ocs_chk.sv
module ocs_chk #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_bit,
   input logic              supply_low,
   input logic              wr_pin,
   input logic              md_pin,
   input logic              calibrating,
   input logic              cal_req,
   input logic              preset_all,
   input logic              preset_gain,
   input logic              corrected,
   input logic [1:0]        op_mode,
   input logic [CODE_W-1:0] trk_code,
   input logic [CODE_W-1:0] foc_code
);
   localparam logic [CODE_W-1:0] DFLT = CODE_W'((1 << (CODE_W - 1)) - 1);

   p_run_forces_rd_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
      calibrating |-> (op_mode == 2'b00 && trk_code == '0 && foc_code == '0));

   p_req_high_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      calibrating |-> cal_req);

   p_brownout_ends_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && supply_low) |=> !calibrating);

   p_sleep_beats_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && sleep_bit) |=> !calibrating);

   p_preset_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      preset_all |-> $past(calibrating));

   p_sleep_gain_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      preset_gain |-> (trk_code == DFLT && foc_code == DFLT));

   p_inhibit_drops_trim_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && wr_pin && md_pin) |=> !corrected);
endmodule

bind ofs_cal_seq ocs_chk #(.CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_bit   (sleep_bit),
   .supply_low  (supply_low),
   .wr_pin      (wr_pin),
   .md_pin      (md_pin),
   .calibrating (calibrating),
   .cal_req     (cal_req),
   .preset_all  (preset_all),
   .preset_gain (preset_gain),
   .corrected   (corrected),
   .op_mode     (op_mode),
   .trk_code    (trk_code),
   .foc_code    (foc_code)
);

// File: tb/tb_ofs_cal_seq.sv
`timescale 1ns/1ps
module tb_ofs_cal_seq;
   localparam int CAL = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr = 1'b0, md = 1'b0, slp = 1'b0, cs = 1'b0;
   logic slo = 1'b0, shi = 1'b0, tev = 1'b0;
   logic [3:0] tcode = 4'd7, fcode = 4'd7;
   logic [1:0] op_mode;
   logic [3:0] trk_code, foc_code;
   logic signed [5:0] trk_db, foc_db;
   logic calibrating, cal_req, corrected, preset_all, preset_gain;
   logic pa_seen = 1'b0, pg_seen = 1'b0;
   int checks = 0, errors = 0;
   bit exp_corr;

   always #10 clk = ~clk;

   ofs_cal_seq #(.CAL_CYCLES(CAL)) dut (
      .clk(clk), .rst_n(rst_n), .wr_pin(wr), .md_pin(md),
      .sleep_bit(slp), .corr_bit(cs), .supply_low(slo), .supply_high(shi),
      .temp_evt(tev), .trk_code_in(tcode), .foc_code_in(fcode),
      .op_mode(op_mode), .trk_code(trk_code), .foc_code(foc_code),
      .trk_db(trk_db), .foc_db(foc_db), .calibrating(calibrating),
      .cal_req(cal_req), .corrected(corrected), .preset_all(preset_all),
      .preset_gain(preset_gain)
   );

   function automatic int db_of(input logic [3:0] c);
      return 14 - 2 * int'(c);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // register file model, then one clock, sample 1 ns after the edge
   task automatic step();
      if (pa_seen) begin tcode = 4'd7; fcode = 4'd7; slp = 1'b0; cs = 1'b0; end
      if (pg_seen) begin tcode = 4'd7; fcode = 4'd7; end
      @(posedge clk); #1;
      pa_seen = preset_all;
      pg_seen = preset_gain;
   endtask

   // called in the first cycle of a run
   task automatic run_to_done(input string tag);
      bit still = 1'b1;
      for (int i = 1; i < CAL; i++) begin
         step();
         if (!calibrating || op_mode != 2'b00 || trk_code != 4'd0) still = 1'b0;
      end
      chk({tag, " R4 run held CAL cycles"}, int'(still), 1);
      step();
      chk({tag, " R4 preset_all"}, int'(preset_all), 1);
      chk({tag, " R4 calibrating low"}, int'(calibrating), 0);
      chk({tag, " R4 default trk code"}, int'(trk_code), 7);
      chk({tag, " R4 default foc code"}, int'(foc_code), 7);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog act=%0d exp=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      md = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R2 reset calibrating", int'(calibrating), 1);
      chk("R2 reset cal_req", int'(cal_req), 1);
      chk("R3 reset op_mode forced", int'(op_mode), 0);
      chk("R3 reset trk code", int'(trk_code), 0);
      chk("R3 reset trk db", int'(trk_db), 14);
      @(negedge clk);
      rst_n = 1'b1;
      md = 1'b0;
      run_to_done("power-up");
      chk("R10 corrected after clean run", int'(corrected), 1);
      chk("R9 cal_req low after run", int'(cal_req), 0);
      step();
      chk("R4 idle after preset", int'(preset_all), 0);

      // random idle traffic
      exp_corr = 1'b1;
      for (int i = 0; i < 40; i++) begin
         wr = 1'($urandom());
         md = 1'($urandom());
         if (i == 5) begin wr = 1'b1; md = 1'b1; end
         tcode = 4'($urandom());
         fcode = 4'($urandom());
         step();
         if (wr && md) exp_corr = 1'b0;
         chk("R1 op_mode decode", int'(op_mode), int'({wr, md}));
         chk("R11 trk code pass", int'(trk_code), int'(tcode));
         chk("R11 trk db", int'(trk_db), db_of(tcode));
         chk("R11 foc db", int'(foc_db), db_of(fcode));
         chk("R10 sticky corrected", int'(corrected), int'(exp_corr));
         chk("R5 no run without command", int'(calibrating), 0);
      end
      wr = 1'b0; md = 1'b0;
      tcode = 4'd0; step();
      chk("R11 code 0000 gives +14", int'(trk_db), 14);
      tcode = 4'd15; step();
      chk("R11 code 1111 gives -16", int'(trk_db), -16);

      // temperature event
      tev = 1'b1; step(); tev = 1'b0;
      chk("R9 temp event raises cal_req", int'(cal_req), 1);
      repeat (3) step();
      chk("R9 cal_req held while waiting", int'(cal_req), 1);
      chk("R9 no self start", int'(calibrating), 0);

      // command start, inhibit applied then released mid-run
      md = 1'b1; cs = 1'b1;
      step();
      chk("R5 command starts run", int'(calibrating), 1);
      chk("R3 ROM pins overridden", int'(op_mode), 0);
      chk("R3 foc db max", int'(foc_db), 14);
      chk("R9 cal_req in run", int'(cal_req), 1);
      for (int i = 1; i < CAL; i++) begin
         if (i == 10) begin wr = 1'b1; md = 1'b1; end
         if (i == 20) begin wr = 1'b0; md = 1'b1; end
         step();
      end
      step();
      chk("R4 preset after inhibited span", int'(preset_all), 1);
      chk("R10 released before finish applies", int'(corrected), 1);
      chk("R9 cal_req falls at stop", int'(cal_req), 0);
      step();

      // inhibit held to the end
      cs = 1'b1; wr = 1'b1; md = 1'b1;
      step();
      chk("R5 start under inhibit", int'(calibrating), 1);
      run_to_done("inhibited");
      chk("R10 inhibited run not applied", int'(corrected), 0);
      wr = 1'b0; md = 1'b0;
      repeat (3) step();
      chk("R10 stays uncorrected after release", int'(corrected), 0);

      // sleep with command pending
      tcode = 4'd3; fcode = 4'd12;
      slp = 1'b1; cs = 1'b1;
      step();
      chk("R6 sleep beats command", int'(calibrating), 0);
      chk("R6 preset_gain pulse", int'(preset_gain), 1);
      chk("R6 trk default in sleep", int'(trk_code), 7);
      chk("R6 foc default in sleep", int'(foc_code), 7);
      step();
      chk("R6 preset_gain one cycle", int'(preset_gain), 0);
      tcode = 4'd5;
      step();
      chk("R6 code held default", int'(trk_code), 7);
      chk("R6 still no run", int'(calibrating), 0);
      slp = 1'b0;
      step();
      chk("R7 sleep exit starts run", int'(calibrating), 1);
      run_to_done("wake");
      step();

      // brownout
      cs = 1'b1;
      step();
      chk("R5 run for brownout test", int'(calibrating), 1);
      repeat (5) step();
      slo = 1'b1;
      step();
      chk("R8 brownout aborts run", int'(calibrating), 0);
      chk("R8 cal_req cleared", int'(cal_req), 0);
      slo = 1'b0;
      repeat (4) step();
      chk("R8 no restart before recovery", int'(calibrating), 0);
      shi = 1'b1;
      step();
      shi = 1'b0;
      chk("R8 recovery starts run", int'(calibrating), 1);
      run_to_done("recovery");
      step();
      chk("R8 idle after recovery run", int'(calibrating), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule